// File: doc/BRIEF.md
# Shared Ready/Busy and Interrupt Status Pin

This block drives one status output whose meaning depends on the card's latched operating mode. In memory mode it reports whether the card can take a new transfer: high means ready, low means busy. In I/O mode it is an active-low interrupt request, given either as a fixed-length low strobe or as a low level that stays until the host reads status. In disk-register mode it is an active-high interrupt request that a device-control disable bit can mask.

After chip reset or a host hardware reset, the pin is held low until the internal initialisation flag reports completion. The host reset input is first brought into the clock domain by a synchroniser. Its active level follows the mode: it is active high in memory and I/O modes and active low in disk-register mode. The reset also clears any pending interrupt. The command engine that drives the busy flag and the interrupt event is outside this block.

Top module: `rsp_status_pin`

## Requirements
- R1: After `rst_n` goes low, or after a synchronised host reset, `status_pin` stays 0 in every mode. It stays 0 until a clock edge where the synchronised host reset is inactive and `init_done` is 1.
- R2: A change on `hw_reset_raw` is seen through a `SYNC_STAGES`-flop synchroniser (default 2). The first clock edge after the input changes is edge 1. The hold takes effect at edge `SYNC_STAGES+1`.
- R3: The mode input `mode_sel` uses these encodings: 2'b00 memory, 2'b01 I/O, 2'b10 disk-register, 2'b11 treated as memory. `hw_reset_raw` asserts reset when high in memory and I/O modes, and when low in disk-register mode.
- R4: In memory mode, with no hold, `status_pin` equals the inverse of `busy` as sampled at the previous clock edge.
- R5: In I/O mode with `pulse_sel`=1, an accepted `irq_event` drives `status_pin` to 0 for exactly `PULSE_LEN` cycles (default 8), starting right after the sampling edge. A new event during a strobe restarts the full length.
- R6: In I/O mode with `pulse_sel`=0, an accepted event drives `status_pin` to 0 and keeps it there. The interrupt clears to 1 after the edge that samples `status_rd`=1.
- R7: In disk-register mode, a pending interrupt drives `status_pin` to 1. No pending interrupt gives 0. A status read clears the pending interrupt.
- R8: In disk-register mode, `irq_disable`=1 (sampled at the previous edge) forces `status_pin` to 0. The pending interrupt is kept, so the pin returns to 1 once the disable is removed.
- R9: An `irq_event` sampled while the hold or synchronised host reset is active is discarded. A host reset also clears any pending interrupt.
- R10: When `irq_event` and `status_rd` are sampled on the same edge, the event wins and the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| mode_sel | input | 2 | Latched operating mode (see R3) |
| hw_reset_raw | input | 1 | Host hardware reset, polarity per mode, asynchronous |
| init_done | input | 1 | Internal initialisation complete |
| busy | input | 1 | Internal busy flag from the command engine |
| irq_event | input | 1 | One-cycle interrupt event |
| pulse_sel | input | 1 | 1 selects strobe interrupts in I/O mode, 0 selects level |
| status_rd | input | 1 | Host read of the status register (clears pending) |
| irq_disable | input | 1 | Device-control interrupt disable for disk-register mode |
| status_pin | output | 1 | Shared ready/busy / interrupt status output |

## Verification
Some internal faults show only at the pin. A stuck hold flag keeps the pin low from the first cycle after reset release, in every mode. A lost pending flag shows in the cycle after the event. In level or disk modes the pin does not move. With the disable bit set, the fault hides until the disable drops and the pin fails to come back high. A pulse counter with a wrong reload or decrement makes the strobe one or more cycles too long or too short, and this is visible only at its trailing edge. A synchroniser with the wrong depth shifts the hold edge by whole cycles. The bench therefore compares the pin against a reference model on every clock instead of only at chosen points.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [1:0] {
    MODE_MEM  = 2'b00,
    MODE_IO   = 2'b01,
    MODE_DISK = 2'b10,
    MODE_RSVD = 2'b11
  } port_mode_e;
endpackage

// File: rtl/rsp_reset_hold.sv
module rsp_reset_hold #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_reset_raw,
  input  logic disk_mode,
  input  logic init_done,
  output logic rst_active,
  output logic hold
);
  logic                   assert_raw;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   hold_q, hold_d;

  // host reset level: active low in disk-register mode, active high elsewhere
  assign assert_raw = disk_mode ? ~hw_reset_raw : hw_reset_raw;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = assert_raw;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], assert_raw};
    end
  endgenerate

  always_comb begin
    hold_d = hold_q;
    if (sync_q[SYNC_STAGES-1])
      hold_d = 1'b1;
    else if (init_done)
      hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hold_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      hold_q <= hold_d;
    end
  end

  assign rst_active = sync_q[SYNC_STAGES-1];
  assign hold       = hold_q;

  // R1
  hold_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> hold);
  // R1
  hold_needs_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !init_done) |=> hold);
endmodule

// File: rtl/rsp_irq_source.sv
module rsp_irq_source #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet,
  input  logic pulse_mode,
  input  logic irq_event,
  input  logic status_rd,
  output logic pending,
  output logic pulse_on
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_LEN);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  assign accept = irq_event && !quiet;

  always_comb begin
    pend_d = pend_q;
    if (quiet)
      pend_d = 1'b0;
    else if (accept && !pulse_mode)
      pend_d = 1'b1;
    else if (status_rd)
      pend_d = 1'b0;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (quiet)
      cnt_d = '0;
    else if (accept && pulse_mode)
      cnt_d = RELOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pending  = pend_q;
  assign pulse_on = (cnt_q != '0);

  // R9
  quiet_drops_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> !pending);
  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !irq_event && !quiet) |=> !pending);
  // R10
  event_beats_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event && !quiet && !pulse_mode) |=> pending);
  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event && !quiet && pulse_mode) |=> pulse_on);
  // R5
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);
endmodule

// File: rtl/rsp_pin_mux.sv
module rsp_pin_mux
  import rsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  port_mode_e mode,
  input  logic       hold,
  input  logic       busy,
  input  logic       irq_disable,
  input  logic       pulse_sel,
  input  logic       pending,
  input  logic       pulse_on,
  output logic       pin
);
  logic busy_q, nien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      nien_q <= 1'b0;
    end else begin
      busy_q <= busy;
      nien_q <= irq_disable;
    end
  end

  always_comb begin
    if (hold) begin
      pin = 1'b0;
    end else begin
      unique case (mode)
        MODE_IO:   pin = pulse_sel ? !pulse_on : !pending;
        MODE_DISK: pin = pending && !nien_q;
        default:   pin = !busy_q;
      endcase
    end
  end

  // R1
  hold_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !pin);
  // R8
  disk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DISK && nien_q) |-> !pin);
endmodule

// File: rtl/rsp_status_pin.sv
module rsp_status_pin
  import rsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       hw_reset_raw,
  input  logic       init_done,
  input  logic       busy,
  input  logic       irq_event,
  input  logic       pulse_sel,
  input  logic       status_rd,
  input  logic       irq_disable,
  output logic       status_pin
);
  port_mode_e mode;
  logic       rst_active, hold, quiet, pulse_mode;
  logic       pending, pulse_on;

  assign mode       = port_mode_e'(mode_sel);
  assign quiet      = hold || rst_active;
  assign pulse_mode = (mode == MODE_IO) && pulse_sel;

  rsp_reset_hold #(.SYNC_STAGES(SYNC_STAGES)) u_hold (
    .clk(clk), .rst_n(rst_n), .hw_reset_raw(hw_reset_raw),
    .disk_mode(mode == MODE_DISK), .init_done(init_done),
    .rst_active(rst_active), .hold(hold)
  );

  rsp_irq_source #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk(clk), .rst_n(rst_n), .quiet(quiet), .pulse_mode(pulse_mode),
    .irq_event(irq_event), .status_rd(status_rd),
    .pending(pending), .pulse_on(pulse_on)
  );

  rsp_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hold(hold), .busy(busy),
    .irq_disable(irq_disable), .pulse_sel(pulse_sel), .pending(pending),
    .pulse_on(pulse_on), .pin(status_pin)
  );

  // R4
  mem_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !rst_active && mode == MODE_MEM && !busy) |=>
      (hold || mode != MODE_MEM || status_pin));
endmodule

// File: tb/sim_rsp_status_pin.sv
module sim_rsp_status_pin;
  localparam int SYNC = 2;
  localparam int PLEN = 8;

  logic clk = 1'b0;
  logic rst_n, hw_reset_raw, init_done, busy, irq_event, pulse_sel, status_rd, irq_disable;
  logic [1:0] mode_sel;
  logic status_pin;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rsp_status_pin #(.SYNC_STAGES(SYNC), .PULSE_LEN(PLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hw_reset_raw(hw_reset_raw),
    .init_done(init_done), .busy(busy), .irq_event(irq_event),
    .pulse_sel(pulse_sel), .status_rd(status_rd), .irq_disable(irq_disable),
    .status_pin(status_pin)
  );

  // behavioural reference model
  bit sq[$];
  bit m_hold, m_pend, m_busy, m_nien;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq = {};
      for (int i = 0; i < SYNC; i++) sq.push_back(1'b1);
      m_hold = 1; m_pend = 0; m_cnt = 0; m_busy = 1; m_nien = 0;
    end else begin
      bit act, quiet, pm, raw_act;
      act   = sq[SYNC-1];
      quiet = m_hold || act;
      pm    = (mode_sel == 2'b01) && pulse_sel;
      if (quiet) m_pend = 0;
      else if (irq_event && !pm) m_pend = 1;
      else if (status_rd) m_pend = 0;
      if (quiet) m_cnt = 0;
      else if (irq_event && pm) m_cnt = PLEN;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (act) m_hold = 1;
      else if (init_done) m_hold = 0;
      m_busy = busy;
      m_nien = irq_disable;
      raw_act = (mode_sel == 2'b10) ? !hw_reset_raw : hw_reset_raw;
      sq.push_front(raw_act);
      void'(sq.pop_back());
    end
  end

  function automatic bit exp_pin();
    if (m_hold) return 1'b0;
    case (mode_sel)
      2'b01:   return pulse_sel ? (m_cnt == 0) : !m_pend;
      2'b10:   return m_pend && !m_nien;
      default: return !m_busy;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input bit act, input bit exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: status_pin=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // advance n cycles, comparing with the model after each edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(status_pin === exp_pin(), cur_req, status_pin, exp_pin());
      irq_event = 0;
      status_rd = 0;
    end
  endtask

  task automatic expect_pin(input bit exp, input string req);
    check(status_pin === exp, req, status_pin, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: status_pin=%0b expected=done", status_pin);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lows;
    rst_n = 0; mode_sel = 2'b00; hw_reset_raw = 0; init_done = 0; busy = 0;
    irq_event = 0; pulse_sel = 0; status_rd = 0; irq_disable = 0;
    repeat (3) @(negedge clk);
    expect_pin(1'b0, "R1");
    rst_n = 1;
    cur_req = "R1"; tick(5);
    expect_pin(1'b0, "R1");             // no init_done yet
    init_done = 1; tick(1);
    expect_pin(1'b1, "R1");             // hold released, ready

    cur_req = "R4";
    busy = 1; tick(1); expect_pin(1'b0, "R4");
    busy = 0; tick(1); expect_pin(1'b1, "R4");
    mode_sel = 2'b11; busy = 1; tick(1); expect_pin(1'b0, "R3");
    busy = 0; mode_sel = 2'b00; tick(1);

    cur_req = "R2";
    hw_reset_raw = 1;
    tick(2); expect_pin(1'b1, "R2");
    tick(1); expect_pin(1'b0, "R2");
    hw_reset_raw = 0;
    tick(2); expect_pin(1'b0, "R2");
    tick(1); expect_pin(1'b1, "R2");

    cur_req = "R6";
    mode_sel = 2'b01; pulse_sel = 0; tick(1);
    expect_pin(1'b1, "R6");
    irq_event = 1; tick(1); expect_pin(1'b0, "R6");
    tick(5); expect_pin(1'b0, "R6");
    status_rd = 1; tick(1); expect_pin(1'b1, "R6");

    cur_req = "R9";
    irq_event = 1; tick(1); expect_pin(1'b0, "R9");
    hw_reset_raw = 1; tick(4);
    hw_reset_raw = 0; irq_event = 1; tick(1);
    tick(4); expect_pin(1'b1, "R9");    // pending cleared, held event dropped

    cur_req = "R5";
    pulse_sel = 1; tick(1);
    irq_event = 1; lows = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (!status_pin) lows++;
    end
    check(lows == PLEN, "R5", lows == PLEN, 1'b1);
    if (lows != PLEN) $display("FAIL R5: low cycles=%0d expected=%0d", lows, PLEN);
    irq_event = 1; lows = 0;
    for (int i = 0; i < 4; i++) begin tick(1); if (!status_pin) lows++; end
    irq_event = 1;
    for (int i = 0; i < 20; i++) begin tick(1); if (!status_pin) lows++; end
    check(lows == PLEN + 4, "R5", lows == PLEN + 4, 1'b1);
    if (lows != PLEN + 4) $display("FAIL R5: retrigger low cycles=%0d expected=%0d", lows, PLEN + 4);

    cur_req = "R3";
    hw_reset_raw = 0; mode_sel = 2'b10;  // low = reset asserted in disk mode
    tick(4); expect_pin(1'b0, "R3");
    irq_event = 1; tick(1);
    hw_reset_raw = 1; tick(4);
    cur_req = "R9";
    expect_pin(1'b0, "R9");             // event during hold discarded

    cur_req = "R7";
    irq_event = 1; tick(1); expect_pin(1'b1, "R7");
    cur_req = "R8";
    irq_disable = 1; tick(1); expect_pin(1'b0, "R8");
    tick(3); expect_pin(1'b0, "R8");
    irq_disable = 0; tick(1); expect_pin(1'b1, "R8");
    cur_req = "R10";
    irq_event = 1; status_rd = 1; tick(1); expect_pin(1'b1, "R10");
    cur_req = "R7";
    status_rd = 1; tick(1); expect_pin(1'b0, "R7");
    tick(3);

    cur_req = "R1";
    init_done = 0; rst_n = 0; @(negedge clk);
    expect_pin(1'b0, "R1");
    rst_n = 1; tick(3); expect_pin(1'b0, "R1");
    init_done = 1; tick(2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule